// File: doc/BRIEF.md
# Tachometer-Clocked Line Phase Accumulator

This block measures where an incoming video line sync falls relative to the machine's own scan timing. A fast tick from the chain-drive tachometer advances a 7-bit counter through a small prescaler. Each rising edge of the video sync clears both the prescaler and the counter and starts a new measurement. Once per scanned line, the rising edge of the head sync copies the running count into an output register and raises a one-cycle valid strobe. Downstream loop logic therefore gets exactly one phase sample per line.

The count is clocked by the drive tachometer and not by a crystal. At any drive speed, one tick is therefore a fixed fraction of the line, and the count scales with the mechanical position. A correct alignment places the video sync a quarter period away from the tachometer phasing reference. That position reads as roughly mid-scale (64 with the default width). A count that runs out of range stops at its top value and does not wrap, so a missing video sync can never look like a small phase error.

The counting is driven by a three-state machine held in the state register:
- IDLE is the state after reset. No sync has been seen yet, the count stays at zero and ticks are ignored.
- COUNT advances the count on prescaler carries.
- FULL holds the count at its maximum and ignores ticks.

The transitions are:
- IDLE→COUNT on a video sync edge.
- COUNT→COUNT on a video sync edge, which restarts the measurement.
- COUNT→FULL when a carry arrives at maximum minus one.
- FULL→COUNT on a video sync edge.

Top module: `phase_accumulator`

## Requirements
- R1: After reset `phase_out` is 0 and `sample_valid` is 0. Until the first video sync rising edge the machine stays in IDLE: tachometer edges have no effect, and a head sync latches 0.
- R2: A video sync rising edge sets the count to 0 and enters COUNT. After that, every PRESC_DIV-th tachometer rising edge (default 2) adds one to the count. The prescaler phase also restarts on the video sync edge.
- R3: When the count reaches 127, the machine enters FULL. Further tachometer edges leave it at 127 until the next video sync edge.
- R4: A head sync rising edge copies the count into `phase_out` at that same clock edge. `phase_out` keeps its value in every other cycle.
- R5: If a head sync edge and a video sync edge fall in the same cycle, `phase_out` receives the count from before the restart.
- R6: `sample_valid` is high for exactly the one cycle following each head sync rising edge, and low otherwise.
- R7: Each input acts only on a low-to-high transition (high now, low in the previous cycle). A level held high for many cycles acts once.
- R8: If a tachometer edge and a video sync edge fall in the same cycle, the restart wins. That tick is lost and neither the count nor the prescaler advances.
- R9: If a tachometer edge and a head sync edge fall in the same cycle, the latched value does not include that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Drive tachometer tick, synchronous |
| vsync_in | input | 1 | Video line sync, synchronous |
| hsync_in | input | 1 | Head (scan line) sync, synchronous |
| phase_out | output | CNT_W (7) | Latched phase count |
| sample_valid | output | 1 | One-cycle strobe after each latch update |

## Verification
The bench goes after the coincidences: head sync together with video sync, tachometer together with video sync, and tachometer together with head sync.
- A design that ordered the head sync wrongly would latch 0 instead of the old count.
- A design that ordered the tachometer wrongly would report one count too many, or shift the prescaler phase.
- A long run without a video sync checks that the count stops at 127; a wrapping counter would report a small value.
- Inputs held high for several cycles check that a level-sensitive design does not count the same tick repeatedly.
- Ticks before the first sync check that the IDLE state really holds the count at zero.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FULL  = 2'd2
    } pa_state_e;
endpackage

// File: rtl/pa_edge_detect.sv
module pa_edge_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic tick,
    output logic carry
);
    generate
        if (DIV <= 1) begin : g_direct
            assign carry = enable && tick && !clear;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                div_q <= '0;
                else if (clear)            div_q <= '0;
                else if (enable && tick)   div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            assign carry = enable && tick && !clear && (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pa_count_fsm.sv
module pa_count_fsm
    import pa_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             carry,
    output pa_state_e        state,
    output logic [CNT_W-1:0] count,
    output logic             count_en
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NEAR = MAXV - 1'b1;

    pa_state_e state_q, state_d;
    logic [CNT_W-1:0] count_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (restart) state_d = ST_COUNT;
            ST_COUNT: begin
                if (restart)                        state_d = ST_COUNT;
                else if (carry && count_q == NEAR)  state_d = ST_FULL;
            end
            ST_FULL:  if (restart) state_d = ST_COUNT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          count_q <= '0;
        else if (restart)                                    count_q <= '0;
        else if (carry && state_q == ST_COUNT && count_q != MAXV) count_q <= count_q + 1'b1;
    end

    always_comb begin
        count_en = (state_q == ST_COUNT);
        state    = state_q;
        count    = count_q;
    end
endmodule

// File: rtl/phase_accumulator.sv
module phase_accumulator
    import pa_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int PRESC_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             vsync_in,
    input  logic             hsync_in,
    output logic [CNT_W-1:0] phase_out,
    output logic             sample_valid
);
    logic [2:0] rise;
    logic       tach_e, vsync_e, hsync_e;
    logic       carry, count_en;
    pa_state_e        state_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] phase_q;
    logic             valid_q;

    pa_edge_detect #(.W(3)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({hsync_in, vsync_in, tach_in}),
        .rise (rise)
    );

    assign tach_e  = rise[0];
    assign vsync_e = rise[1];
    assign hsync_e = rise[2];

    pa_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (vsync_e),
        .enable(count_en),
        .tick  (tach_e),
        .carry (carry)
    );

    pa_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (vsync_e),
        .carry   (carry),
        .state   (state_w),
        .count   (count_w),
        .count_en(count_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= hsync_e;
            if (hsync_e) phase_q <= count_w;
        end
    end

    assign phase_out    = phase_q;
    assign sample_valid = valid_q;
endmodule

// File: rtl/pa_checker.sv
module pa_checker
    import pa_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_in,
    input logic             sample_valid,
    input logic [CNT_W-1:0] phase_out,
    input logic [CNT_W-1:0] count,
    input pa_state_e        state
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> count == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count != $past(count) |-> (count == $past(count) + 1'b1 || count == '0));

    p_full_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL |-> count == MAXV);

    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(phase_out));

    p_valid_after_hsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_in && !$past(hsync_in)) |=> sample_valid);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
endmodule

bind phase_accumulator pa_checker #(.CNT_W(CNT_W)) u_pa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_in    (hsync_in),
    .sample_valid(sample_valid),
    .phase_out   (phase_out),
    .count       (count_w),
    .state       (state_w)
);

// File: tb/phase_accumulator_test.sv
`timescale 1ns/1ps
module phase_accumulator_test;
    localparam int CW  = 7;
    localparam int DIV = 2;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tach_in = 1'b0, vsync_in = 1'b0, hsync_in = 1'b0;
    logic [CW-1:0] phase_out;
    logic sample_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    bit pt, pv, ph;
    int m_st;   // 0 idle, 1 count, 2 full
    int m_cnt, m_pre, m_phase;
    bit m_valid;

    always #10 clk = ~clk;

    phase_accumulator #(.CNT_W(CW), .PRESC_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .vsync_in(vsync_in),
        .hsync_in(hsync_in), .phase_out(phase_out), .sample_valid(sample_valid)
    );

    function automatic void model_reset();
        pt = 0; pv = 0; ph = 0;
        m_st = 0; m_cnt = 0; m_pre = 0; m_phase = 0; m_valid = 0;
    endfunction

    function automatic void model_step(bit t, bit v, bit h);
        bit te, ve, he;
        te = t && !pt; ve = v && !pv; he = h && !ph;
        m_valid = he;
        if (he) m_phase = m_cnt;
        if (ve) begin
            m_st = 1; m_cnt = 0; m_pre = 0;
        end else if (m_st == 1 && te) begin
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_cnt < MAXC) m_cnt++;
                if (m_cnt == MAXC) m_st = 2;
            end else begin
                m_pre++;
            end
        end
        pt = t; pv = v; ph = h;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit t, bit v, bit h, string tag);
        tach_in = t; vsync_in = v; hsync_in = h;
        @(posedge clk);
        model_step(t, v, h);
        @(negedge clk);
        check(tag, int'(phase_out), m_phase, "phase_out");
        check(tag, int'(sample_valid), int'(m_valid), "sample_valid");
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, tag);
            step(0, 0, 0, tag);
        end
    endtask

    task automatic sample(int exp, string tag);
        step(0, 0, 1, tag);
        check(tag, int'(phase_out), exp, "direct phase");
        step(0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        check("R1", int'(phase_out), 0, "reset phase");
        check("R1", int'(sample_valid), 0, "reset valid");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ticks before the first video sync are ignored
        ticks(6, "R1");
        sample(0, "R1");

        // R2: restart then 10 ticks -> 5 counts
        step(0, 1, 0, "R2"); step(0, 0, 0, "R2");
        ticks(10, "R2");
        sample(5, "R2");
        // R4: phase holds while more ticks arrive
        ticks(4, "R4");
        check("R4", int'(phase_out), 5, "held phase");
        sample(7, "R4");

        // R7: held-high tach counts once, held-high hsync pulses valid once
        step(0, 1, 0, "R7"); step(0, 0, 0, "R7");
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R7");
        step(0, 0, 0, "R7");
        ticks(1, "R7");
        step(0, 0, 1, "R7");
        check("R7", int'(phase_out), 1, "held tach");
        step(0, 0, 1, "R7");
        check("R7", int'(sample_valid), 0, "held hsync");
        step(0, 0, 0, "R7");

        // R5: head sync with video sync latches old count
        step(0, 1, 0, "R5"); step(0, 0, 0, "R5");
        ticks(6, "R5");
        step(0, 1, 1, "R5");
        check("R5", int'(phase_out), 3, "coincident latch");
        step(0, 0, 0, "R5");
        sample(0, "R5");

        // R8: tach with video sync is lost, prescaler restarted
        ticks(1, "R8");               // prescaler half way
        step(1, 1, 0, "R8"); step(0, 0, 0, "R8");
        ticks(1, "R8");
        sample(0, "R8");
        ticks(1, "R8");
        sample(1, "R8");

        // R9: tach with head sync excluded from latched value
        step(0, 1, 0, "R9"); step(0, 0, 0, "R9");
        ticks(3, "R9");
        step(1, 0, 1, "R9");
        check("R9", int'(phase_out), 1, "tach with hsync");
        step(0, 0, 0, "R9");
        sample(2, "R9");

        // R3: saturation and recovery
        step(0, 1, 0, "R3"); step(0, 0, 0, "R3");
        ticks(300, "R3");
        sample(MAXC, "R3");
        ticks(20, "R3");
        sample(MAXC, "R3");
        step(0, 1, 0, "R3"); step(0, 0, 0, "R3");
        ticks(4, "R3");
        sample(2, "R3");

        // R6 / R2 / R4: constrained random stream
        for (int i = 0; i < 6000; i++) begin
            bit t, v, h;
            t = ($urandom % 2) == 0;
            v = ($urandom % 180) == 0;
            h = ($urandom % 37) == 0;
            step(t, v, h, "R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule